// File: doc/BRIEF.md
# Call/Return Link Unit with Flag Save

This unit steers the program counter of a small processor core that has a 9-bit program counter and two condition flags, zero and carry. It handles four instruction classes: hold, step, call and return.

On a call, the unit forms a link word and writes it to a register through a write port. The link word holds the return address. It can also hold either flag, or both, depending on two modifier bits that come with the instruction. The unit then jumps to the call target. On a return, the unit takes a link word from the register read data and reloads the program counter from it. It restores each flag whose modifier is set.

The flags sit just above the return address in the link word, at bits 10 and 9. In an instruction word, those two bits are the low bits of the destination field. A flagged link can therefore be stored safely in a jump or return word, which ignores that field. It must not be stored into a call word.

The register file sits outside the unit. The unit names one register per instruction, and the register file returns that register's current contents on `reg_rdata` in the same cycle. On a call, `reg_rdata` is the old value of the destination register, which the unit merges with the link fields. On a return, `reg_rdata` is the link word.

Top module: `callret_link`

## Requirements
- R1: After reset, and before any instruction, `pc` is 0, both flags are 0 and `reg_we` is 0.
- R2: The `op_class` encoding is 00 hold, 01 step, 10 call, 11 return. A call sets `pc` to `op_target` on the next edge. In the same cycle it drives `reg_we`=1 and `reg_waddr`=`op_reg`, and bits 8..0 of `reg_wdata` equal the old `pc` plus 1, modulo 512.
- R3: On a call with `mod_z`=1, bit 10 of `reg_wdata` holds the zero flag. With `mod_z`=0, bit 10 is copied from `reg_rdata` bit 10.
- R4: On a call with `mod_c`=1, bit 9 of `reg_wdata` holds the carry flag. With `mod_c`=0, bit 9 is copied from `reg_rdata` bit 9.
- R5: On a call, bits 31..11 of `reg_wdata` equal bits 31..11 of `reg_rdata`.
- R6: A return loads `pc` from `reg_rdata` bits 8..0 on the next edge. Bits 31..11 have no effect on `pc`.
- R7: On a return, `mod_z`=1 loads the zero flag from `reg_rdata` bit 10, and `mod_c`=1 loads the carry flag from bit 9. A flag whose modifier is 0 keeps its value. No other class changes a flag.
- R8: A step advances `pc` by 1, modulo 512. A hold leaves `pc` unchanged.
- R9: `reg_we` is 1 for exactly one cycle after each call, and is 0 after every other class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| op_class | input | 2 | Instruction class: 00 hold, 01 step, 10 call, 11 return |
| op_target | input | 9 | Call target address |
| op_reg | input | 4 | Register named by the instruction: the link destination on a call, the link source on a return |
| mod_z | input | 1 | Zero-flag modifier: save it on a call, restore it on a return |
| mod_c | input | 1 | Carry-flag modifier: save it on a call, restore it on a return |
| reg_rdata | input | 32 | Current contents of register `op_reg` |
| pc | output | 9 | Program counter |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| reg_we | output | 1 | Register write enable |
| reg_waddr | output | 4 | Register write address |
| reg_wdata | output | 32 | Register write data |

## Verification
Flag and program-counter state reach the ports one edge after each instruction. The flags also come back through the link word of the next call that saves them.

A flag restored wrongly by a return first shows on `flag_z` or `flag_c`. It then spreads into bit 10 or 9 of every later saving call. A wrong merge of the upper bits, or of an unsaved flag bit, shows on `reg_wdata` on the same edge as the call.

A random mix of classes makes each such error visible within a few instructions. The directed cases cover return words with junk upper bits and a call at address 511, whose return address wraps to 0.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_STEP = 2'b01,
    OP_CALL = 2'b10,
    OP_RET  = 2'b11
  } op_class_e;
endpackage

// File: rtl/cfl_rst_sync.sv
module cfl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/cfl_link_pack.sv
module cfl_link_pack #(
  parameter int DATA_W = 32,
  parameter int PC_W   = 9
) (
  input  logic [PC_W-1:0]   ret_addr,
  input  logic              cur_z,
  input  logic              cur_c,
  input  logic              save_z,
  input  logic              save_c,
  input  logic [DATA_W-1:0] old_word,
  output logic [DATA_W-1:0] link_word
);
  localparam int C_POS = PC_W;
  localparam int Z_POS = PC_W + 1;

  always_comb begin
    link_word = old_word;
    link_word[PC_W-1:0] = ret_addr;
    if (save_c) link_word[C_POS] = cur_c;
    if (save_z) link_word[Z_POS] = cur_z;
  end
endmodule

// File: rtl/cfl_link_unpack.sv
module cfl_link_unpack #(
  parameter int DATA_W = 32,
  parameter int PC_W   = 9
) (
  input  logic [DATA_W-1:0] link_word,
  output logic [PC_W-1:0]   ret_addr,
  output logic              link_z,
  output logic              link_c
);
  localparam int C_POS = PC_W;
  localparam int Z_POS = PC_W + 1;

  assign ret_addr = link_word[PC_W-1:0];
  assign link_c   = link_word[C_POS];
  assign link_z   = link_word[Z_POS];
endmodule

// File: rtl/callret_link.sv
module callret_link
  import cfl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 9,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_class,
  input  logic [PC_W-1:0]   op_target,
  input  logic [REG_AW-1:0] op_reg,
  input  logic              mod_z,
  input  logic              mod_c,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [PC_W-1:0]   pc,
  output logic              flag_z,
  output logic              flag_c,
  output logic              reg_we,
  output logic [REG_AW-1:0] reg_waddr,
  output logic [DATA_W-1:0] reg_wdata
);
  localparam int LINK_W = PC_W + 2;

  logic rst_n_s;
  op_class_e op;
  logic [PC_W-1:0]   pc_q, pc_d, pc_inc, ret_pc;
  logic              z_q, z_d, c_q, c_d, link_z, link_c;
  logic              we_q, we_d;
  logic [REG_AW-1:0] waddr_q;
  logic [DATA_W-1:0] wdata_q, link_word;
  logic              state_en, wr_en;

  cfl_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  assign op     = op_class_e'(op_class);
  assign pc_inc = pc_q + PC_W'(1);

  cfl_link_pack #(.DATA_W(DATA_W), .PC_W(PC_W)) u_pack (
    .ret_addr(pc_inc), .cur_z(z_q), .cur_c(c_q),
    .save_z(mod_z), .save_c(mod_c),
    .old_word(reg_rdata), .link_word(link_word)
  );

  cfl_link_unpack #(.DATA_W(DATA_W), .PC_W(PC_W)) u_unpack (
    .link_word(reg_rdata), .ret_addr(ret_pc),
    .link_z(link_z), .link_c(link_c)
  );

  // next state
  always_comb begin
    pc_d = pc_q;
    z_d  = z_q;
    c_d  = c_q;
    we_d = 1'b0;
    unique case (op)
      OP_HOLD: ;
      OP_STEP: pc_d = pc_inc;
      OP_CALL: begin
        pc_d = op_target;
        we_d = 1'b1;
      end
      OP_RET: begin
        pc_d = ret_pc;
        if (mod_z) z_d = link_z;
        if (mod_c) c_d = link_c;
      end
      default: ;
    endcase
  end

  assign state_en = (op != OP_HOLD);
  assign wr_en    = (op == OP_CALL);

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pc_q <= '0;
      z_q  <= 1'b0;
      c_q  <= 1'b0;
    end else if (state_en) begin
      pc_q <= pc_d;
      z_q  <= z_d;
      c_q  <= c_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) we_q <= 1'b0;
    else          we_q <= we_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      waddr_q <= '0;
      wdata_q <= '0;
    end else if (wr_en) begin
      waddr_q <= op_reg;
      wdata_q <= link_word;
    end
  end

  assign pc        = pc_q;
  assign flag_z    = z_q;
  assign flag_c    = c_q;
  assign reg_we    = we_q;
  assign reg_waddr = waddr_q;
  assign reg_wdata = wdata_q;

  // R2: a call lands on its target
  a_r2_call_target: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_class == 2'b10) |=> (pc == $past(op_target)));

  // R6: a return loads pc from the low link bits only
  a_r6_ret_pc: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_class == 2'b11) |=> (pc == $past(reg_rdata[PC_W-1:0])));

  // R7: flags move only on a return with the modifier set
  a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_class != 2'b11) |=> ($stable(flag_z) && $stable(flag_c)));

  a_r7_z_restore: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_class == 2'b11 && mod_z) |=> (flag_z == $past(reg_rdata[LINK_W-1])));

  // R8: hold freezes pc
  a_r8_hold_pc: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_class == 2'b00) |=> $stable(pc));

  // R9: the write strobe follows a call and only a call
  a_r9_we_after_call: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_class == 2'b10) |=> reg_we);

  a_r9_no_we_otherwise: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_class != 2'b10) |=> !reg_we);

  // R5: upper bits of the written word follow the old register value
  a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_class == 2'b10) |=> (reg_wdata[DATA_W-1:LINK_W] == $past(reg_rdata[DATA_W-1:LINK_W])));
endmodule

// File: tb/callret_link_bench.sv
`timescale 1ns/1ps
module callret_link_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  op_class;
  logic [8:0]  op_target;
  logic [3:0]  op_reg;
  logic        mod_z, mod_c;
  logic [31:0] reg_rdata;
  logic [8:0]  pc;
  logic        flag_z, flag_c, reg_we;
  logic [3:0]  reg_waddr;
  logic [31:0] reg_wdata;

  int errors = 0;
  int checks = 0;

  // model state
  logic [8:0]  m_pc;
  logic        m_z, m_c, m_we;
  logic [3:0]  m_waddr;
  logic [31:0] m_wdata;

  always #10 clk = ~clk;

  callret_link u_callret_link (
    .clk(clk), .rst_n(rst_n), .op_class(op_class), .op_target(op_target),
    .op_reg(op_reg), .mod_z(mod_z), .mod_c(mod_c), .reg_rdata(reg_rdata),
    .pc(pc), .flag_z(flag_z), .flag_c(flag_c), .reg_we(reg_we),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata)
  );

  function automatic logic [31:0] exp_link(input logic [8:0] cur_pc, input logic z,
      input logic c, input logic mz, input logic mc, input logic [31:0] old);
    logic [31:0] w;
    w = old;
    w[8:0] = cur_pc + 9'd1;
    if (mc) w[9] = c;
    if (mz) w[10] = z;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare all outputs with the model (called away from the clock edge)
  task automatic check_outputs(input string tag);
    chk({tag, " pc"}, 32'(pc), 32'(m_pc));
    chk({tag, " flag_z"}, 32'(flag_z), 32'(m_z));
    chk({tag, " flag_c"}, 32'(flag_c), 32'(m_c));
    chk("R9 reg_we", 32'(reg_we), 32'(m_we));
    if (m_we) begin
      chk("R2 reg_waddr", 32'(reg_waddr), 32'(m_waddr));
      chk("R2 link addr", 32'(reg_wdata[8:0]), 32'(m_wdata[8:0]));
      chk("R3 link z", 32'(reg_wdata[10]), 32'(m_wdata[10]));
      chk("R4 link c", 32'(reg_wdata[9]), 32'(m_wdata[9]));
      chk("R5 upper", 32'(reg_wdata[31:11]), 32'(m_wdata[31:11]));
    end
  endtask

  // drive one instruction at the falling edge, check one cycle later
  task automatic issue(input logic [1:0] cls, input logic [8:0] tgt, input logic [3:0] rg,
      input logic mz, input logic mc, input logic [31:0] rd);
    string tag;
    op_class = cls; op_target = tgt; op_reg = rg;
    mod_z = mz; mod_c = mc; reg_rdata = rd;
    m_we = 1'b0;
    case (cls)
      2'b00: tag = "R8 hold";
      2'b01: begin tag = "R8 step"; m_pc = m_pc + 9'd1; end
      2'b10: begin
        tag = "R2 call";
        m_wdata = exp_link(m_pc, m_z, m_c, mz, mc, rd);
        m_waddr = rg;
        m_we = 1'b1;
        m_pc = tgt;
      end
      default: begin
        tag = "R6 R7 ret";
        m_pc = rd[8:0];
        if (mz) m_z = rd[10];
        if (mc) m_c = rd[9];
      end
    endcase
    @(negedge clk);
    check_outputs(tag);
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    op_class = 2'b00; op_target = '0; op_reg = '0;
    mod_z = 0; mod_c = 0; reg_rdata = '0;
    m_pc = '0; m_z = 0; m_c = 0; m_we = 0; m_waddr = '0; m_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 pc", 32'(pc), 32'd0);
    chk("R1 flag_z", 32'(flag_z), 32'd0);
    chk("R1 flag_c", 32'(flag_c), 32'd0);
    chk("R1 reg_we", 32'(reg_we), 32'd0);

    // R7 restore both flags, R6 junk upper bits ignored
    issue(2'b11, 9'd0, 4'd3, 1'b1, 1'b1, 32'hFFFF_F655);
    // R7 restore only carry: z must keep 1
    issue(2'b11, 9'd0, 4'd3, 1'b0, 1'b1, 32'h0000_0010);
    // R2 wrap: jump to 511 then call -> return address 0
    issue(2'b11, 9'd0, 4'd1, 1'b0, 1'b0, 32'hABCD_E9FF);
    issue(2'b10, 9'd77, 4'd9, 1'b1, 1'b1, 32'h1234_5000);
    // R3 R4 unsaved flags keep old register bits
    issue(2'b10, 9'd5, 4'd2, 1'b0, 1'b0, 32'hDEAD_B600);
    issue(2'b10, 9'd6, 4'd2, 1'b0, 1'b0, 32'h0000_0000);
    // R8 step wrap from 511
    issue(2'b11, 9'd0, 4'd0, 1'b0, 1'b0, 32'h0000_01FF);
    issue(2'b01, 9'd0, 4'd0, 1'b0, 1'b0, 32'h0);
    issue(2'b00, 9'd0, 4'd0, 1'b1, 1'b1, 32'hFFFF_FFFF);
    // R9 call then hold: strobe must drop
    issue(2'b10, 9'd300, 4'd15, 1'b1, 1'b0, 32'h8000_0000);
    issue(2'b00, 9'd0, 4'd0, 1'b0, 1'b0, 32'h0);

    for (int i = 0; i < 3000; i++) begin
      issue(2'($urandom_range(3, 0)), 9'($urandom), 4'($urandom),
            1'($urandom), 1'($urandom), $urandom);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule